// File: doc/BRIEF.md
# Reset-Time Boot Page Loader

This block fills an on-chip buffer RAM with the first 4 KB of boot code from flash bank 0. It runs right after reset, before the core is allowed to run. When the reset strap selects flash boot, the loader steps through the first pages of the flash in order. For each page it issues a page command, then reads the page byte by byte over a request/acknowledge handshake. Main-area bytes are written into the buffer so that they form one contiguous image. Spare-area bytes are read past and dropped.

Once the last main byte is stored, `boot_ready` rises, and this is the core's cue to leave reset. After that point the flash interface is never used again. Any further flash traffic is left to software. While the core runs from the buffer, each fetch address is folded modulo the buffer size onto the buffer read port. A flash byte that is not acknowledged within a programmable number of cycles stops the loader and raises `load_err`. In that case `boot_ready` stays low.

Top module: `boot_page_loader`

## Requirements
- R1: While `rst_n` is low, `fl_cmd`, `fl_rd_req`, `buf_we`, `fetch_en`, `boot_ready` and `load_err` are all low.
- R2: If `boot_flash` is low during reset, the loader issues no page command, no read and no buffer write. `boot_ready` goes high one clock edge after reset release.
- R3: With `boot_flash` high, page commands go out in ascending order with `fl_page` = 0, 1, …, 7. Each command lasts one cycle and is followed by that page's byte reads.
- R4: In every page, byte k (counted from 0) is consumed on each cycle where `fl_rd_req` and `fl_rd_ack` are both high. For k < 512, the byte on `fl_rd_data` is written in that same cycle to buffer address page*512 + k. Each of the 4096 addresses is written exactly once.
- R5: Bytes 512 to 527 of pages 0 to 6 are read but never written. The spare bytes of page 7 are not read, so the total is 4208 acknowledged reads.
- R6: `boot_ready` rises in the cycle right after the final buffer write and stays high until reset.
- R7: If `fl_rd_ack` stays low for `ack_timeout` consecutive request cycles (`ack_timeout` ≥ 1), `load_err` goes high in the next cycle. An acknowledge in the last of those cycles is still accepted. After an error, no further reads, commands or writes occur, and `boot_ready` stays low.
- R8: Once `boot_ready` is high, `buf_raddr` equals `core_addr` modulo 4096, and `fetch_en` follows `core_rd`.
- R9: While `boot_ready` is low, `fetch_en` stays low whatever `core_rd` does.
- R10: After `boot_ready` rises, the loader makes no more flash requests or buffer writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_flash | input | 1 | Reset strap: 1 selects loading from flash |
| ack_timeout | input | 16 | Number of request cycles allowed without an acknowledge |
| fl_cmd | output | 1 | One-cycle page command strobe |
| fl_page | output | 3 | Page number sent with the command |
| fl_rd_req | output | 1 | Byte read request |
| fl_rd_ack | input | 1 | Byte read acknowledge |
| fl_rd_data | input | 8 | Byte read data, valid with the acknowledge |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_waddr | output | 12 | Buffer RAM write address |
| buf_wdata | output | 8 | Buffer RAM write data |
| core_rd | input | 1 | Core fetch request |
| core_addr | input | 32 | Core fetch address |
| fetch_en | output | 1 | Buffer RAM read enable for core fetches |
| buf_raddr | output | 12 | Buffer RAM read address |
| boot_ready | output | 1 | Load finished; the core may leave reset |
| load_err | output | 1 | Load stopped on an acknowledge timeout |

## Verification
The assertions rely on four assumptions about the environment:
- `fl_rd_ack` is only raised in a cycle where `fl_rd_req` is high, and `fl_rd_data` is valid alongside it.
- `boot_flash` changes only while `rst_n` is low.
- `ack_timeout` is nonzero.
- `ack_timeout` stays fixed while a load is running.

The bench meets these assumptions by construction. Its flash model acknowledges only when it sees a request in the current cycle. Strap, timeout and stall settings are changed only inside the reset task, while `rst_n` is held low.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_CMD,
    LD_READ,
    LD_DONE,
    LD_FAIL
  } ld_state_e;
endpackage

// File: rtl/bpl_cursor.sv
module bpl_cursor #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_PAGES   = 8,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int BYTE_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int BUF_AW     = $clog2(MAIN_BYTES * NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic              in_main,
  output logic              page_end,
  output logic              load_end,
  output logic [BUF_AW-1:0] buf_addr
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [BYTE_W-1:0] LAST_MAIN = BYTE_W'(MAIN_BYTES - 1);
  localparam logic [BYTE_W-1:0] MAIN_LIM  = BYTE_W'(MAIN_BYTES);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              en;

  assign page_end = (byte_q == LAST_BYTE);
  assign in_main  = (byte_q < MAIN_LIM);
  assign load_end = (page_q == LAST_PAGE) && (byte_q == LAST_MAIN);
  assign page     = page_q;
  assign buf_addr = BUF_AW'(page_q) * BUF_AW'(MAIN_BYTES) + BUF_AW'(byte_q);
  assign en       = clr | step;

  always_comb begin
    byte_d = byte_q;
    page_d = page_q;
    if (clr) begin
      byte_d = '0;
      page_d = '0;
    end else if (step) begin
      if (page_end) begin
        byte_d = '0;
        page_d = page_q + 1'b1;
      end else begin
        byte_d = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      page_q <= '0;
    end else if (en) begin
      byte_q <= byte_d;
      page_q <= page_d;
    end
  end
endmodule

// File: rtl/bpl_ackwatch.sv
module bpl_ackwatch #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ack,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            en;

  assign expire = run && !ack && (cnt_q == limit - 1'b1);
  assign en     = run || (cnt_q != '0);

  always_comb begin
    if (!run || ack) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bpl_fetchmap.sv
module bpl_fetchmap #(
  parameter int ADDR_W = 32,
  parameter int BUF_AW = 12
) (
  input  logic              ready,
  input  logic              core_rd,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              fetch_en,
  output logic [BUF_AW-1:0] buf_raddr
);
  logic unused_hi;

  assign unused_hi = ^core_addr[ADDR_W-1:BUF_AW];
  assign buf_raddr = core_addr[BUF_AW-1:0];
  assign fetch_en  = ready & core_rd;
endmodule

// File: rtl/boot_page_loader.sv
module boot_page_loader #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_PAGES   = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 32,
  parameter int TO_W        = 16,
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int BUF_AW     = $clog2(MAIN_BYTES * NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_flash,
  input  logic [TO_W-1:0]   ack_timeout,
  output logic              fl_cmd,
  output logic [PAGE_W-1:0] fl_page,
  output logic              fl_rd_req,
  input  logic              fl_rd_ack,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic              core_rd,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              fetch_en,
  output logic [BUF_AW-1:0] buf_raddr,
  output logic              boot_ready,
  output logic              load_err
);
  import bpl_pkg::*;

  ld_state_e state_q, state_d;
  logic      in_main, page_end, load_end, expire, take;

  assign fl_cmd     = (state_q == LD_CMD);
  assign fl_rd_req  = (state_q == LD_READ);
  assign boot_ready = (state_q == LD_DONE);
  assign load_err   = (state_q == LD_FAIL);
  assign take       = fl_rd_req && fl_rd_ack;
  assign buf_we     = take && in_main;
  assign buf_wdata  = fl_rd_data;

  bpl_cursor #(
    .MAIN_BYTES (MAIN_BYTES),
    .SPARE_BYTES(SPARE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_q == LD_IDLE),
    .step    (take),
    .page    (fl_page),
    .in_main (in_main),
    .page_end(page_end),
    .load_end(load_end),
    .buf_addr(buf_waddr)
  );

  bpl_ackwatch #(.TO_W(TO_W)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (fl_rd_req),
    .ack   (fl_rd_ack),
    .limit (ack_timeout),
    .expire(expire)
  );

  bpl_fetchmap #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) u_fetch (
    .ready    (boot_ready),
    .core_rd  (core_rd),
    .core_addr(core_addr),
    .fetch_en (fetch_en),
    .buf_raddr(buf_raddr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE: state_d = boot_flash ? LD_CMD : LD_DONE;
      LD_CMD:  state_d = LD_READ;
      LD_READ: begin
        if (take) begin
          if (load_end)      state_d = LD_DONE;
          else if (page_end) state_d = LD_CMD;
        end else if (expire) begin
          state_d = LD_FAIL;
        end
      end
      LD_DONE: state_d = LD_DONE;
      LD_FAIL: state_d = LD_FAIL;
      default: state_d = LD_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/bpl_checker.sv
module bpl_checker (
  input logic clk,
  input logic rst_n,
  input logic boot_flash,
  input logic fl_cmd,
  input logic fl_rd_req,
  input logic fl_rd_ack,
  input logic buf_we,
  input logic fetch_en,
  input logic boot_ready,
  input logic load_err
);
  a_r2_strap_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_flash |-> !fl_cmd && !fl_rd_req && !buf_we);

  a_r3_cmd_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd |=> fl_rd_req);

  a_r4_write_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> fl_rd_req && fl_rd_ack);

  a_r6_ready_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    boot_flash && $rose(boot_ready) |-> $past(buf_we));

  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |=> boot_ready);

  a_r7_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err && !fl_rd_req && !fl_cmd && !buf_we && !boot_ready);

  a_r9_no_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_ready |-> !fetch_en);

  a_r10_flash_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |-> !fl_cmd && !fl_rd_req && !buf_we);

  a_r1_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_cmd, fl_rd_req, boot_ready, load_err}));
endmodule

bind boot_page_loader bpl_checker u_bpl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .boot_flash(boot_flash),
  .fl_cmd    (fl_cmd),
  .fl_rd_req (fl_rd_req),
  .fl_rd_ack (fl_rd_ack),
  .buf_we    (buf_we),
  .fetch_en  (fetch_en),
  .boot_ready(boot_ready),
  .load_err  (load_err)
);

// File: tb/boot_page_loader_test.sv
`timescale 1ns/1ps
module boot_page_loader_test;
  localparam int MAINB = 512;
  localparam int NPG   = 8;
  localparam int BUFB  = MAINB * NPG;

  logic        clk;
  logic        rst_n;
  logic        boot_flash;
  logic [15:0] ack_timeout;
  logic        fl_cmd;
  logic [2:0]  fl_page;
  logic        fl_rd_req;
  logic        fl_rd_ack;
  logic [7:0]  fl_rd_data;
  logic        buf_we;
  logic [11:0] buf_waddr;
  logic [7:0]  buf_wdata;
  logic        core_rd;
  logic [31:0] core_addr;
  logic        fetch_en;
  logic [11:0] buf_raddr;
  logic        boot_ready;
  logic        load_err;

  boot_page_loader uut (
    .clk(clk), .rst_n(rst_n), .boot_flash(boot_flash), .ack_timeout(ack_timeout),
    .fl_cmd(fl_cmd), .fl_page(fl_page), .fl_rd_req(fl_rd_req), .fl_rd_ack(fl_rd_ack),
    .fl_rd_data(fl_rd_data), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .core_rd(core_rd), .core_addr(core_addr), .fetch_en(fetch_en), .buf_raddr(buf_raddr),
    .boot_ready(boot_ready), .load_err(load_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // flash model and buffer observer state
  int   mdl_delay, mdl_stall_at;
  int   cur_page, cur_byte, rd_count, wait_cnt, exp_page, page_bad;
  int   wcount, spare_wr, addr_bad, dup_wr, post_act, cmd_count;
  int   cyc, last_we_cyc, ready_cyc, err_cyc, stall_start;
  logic [7:0] mem [BUFB];
  bit         wr_seen [BUFB];

  function automatic logic [7:0] pat(int p, int k);
    return 8'((p * 29 + k * 3 + (k >> 4)) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      fl_rd_ack <= 1'b0;
    end else begin
      if (fl_rd_ack) begin
        cur_byte++;
        rd_count++;
        wait_cnt = 0;
      end
      fl_rd_ack = 1'b0;
      if (fl_cmd) begin
        cmd_count++;
        if (int'(fl_page) != exp_page) page_bad++;
        exp_page++;
        cur_page = int'(fl_page);
        cur_byte = 0;
        wait_cnt = 0;
      end else if (fl_rd_req) begin
        if (mdl_stall_at >= 0 && rd_count == mdl_stall_at) begin
          if (wait_cnt == 0) stall_start = cyc;
          wait_cnt++;
        end else if (wait_cnt >= mdl_delay) begin
          fl_rd_ack  = 1'b1;
          fl_rd_data = pat(cur_page, cur_byte);
        end else begin
          wait_cnt++;
        end
      end
      #1;
      if (buf_we) begin
        if (!fl_rd_ack || cur_byte >= MAINB) spare_wr++;
        if (int'(buf_waddr) != cur_page * MAINB + cur_byte) addr_bad++;
        if (wr_seen[buf_waddr]) dup_wr++;
        wr_seen[buf_waddr] = 1'b1;
        mem[buf_waddr] = buf_wdata;
        wcount++;
        last_we_cyc = cyc;
      end
      if (boot_ready && (fl_cmd || fl_rd_req || buf_we)) post_act++;
      if (boot_ready && ready_cyc < 0) ready_cyc = cyc;
      if (load_err && err_cyc < 0) err_cyc = cyc;
      cyc++;
    end
  end

  task automatic do_reset(bit flash, int tmo, int delay, int stall_at);
    @(negedge clk); #2;
    rst_n = 1'b0;
    boot_flash = flash;
    ack_timeout = 16'(tmo);
    core_rd = 1'b0;
    core_addr = '0;
    mdl_delay = delay; mdl_stall_at = stall_at;
    cur_page = 0; cur_byte = 0; rd_count = 0; wait_cnt = 0; exp_page = 0; page_bad = 0;
    wcount = 0; spare_wr = 0; addr_bad = 0; dup_wr = 0; post_act = 0; cmd_count = 0;
    cyc = 0; last_we_cyc = -1; ready_cyc = -1; err_cyc = -1; stall_start = -1;
    for (int i = 0; i < BUFB; i++) begin
      wr_seen[i] = 1'b0;
      mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(boot_ready || load_err) && n < 60000) begin
      @(negedge clk); n++;
    end
    @(negedge clk); #2;
  endtask

  task automatic t_reset_state();
    @(negedge clk); #2;
    rst_n = 1'b0; boot_flash = 1'b1; core_rd = 1'b1; core_addr = 32'h10;
    @(negedge clk); #2;
    check(!fl_cmd && !fl_rd_req && !buf_we, "R1", "flash/buffer strobes in reset",
          int'({fl_cmd, fl_rd_req, buf_we}), 0);
    check(!boot_ready && !load_err && !fetch_en, "R1", "status/fetch in reset",
          int'({boot_ready, load_err, fetch_en}), 0);
  endtask

  task automatic t_full_load(int tmo, int delay, string tag);
    int bad = 0;
    do_reset(1'b1, tmo, delay, -1);
    core_rd = 1'b1; core_addr = 32'h0000_0040;
    repeat (20) @(negedge clk);
    #2 check(!fetch_en, "R9", {tag, " fetch during load"}, int'(fetch_en), 0);
    wait_end();
    check(!load_err, "R7", {tag, " no error"}, int'(load_err), 0);
    check(cmd_count == 8 && page_bad == 0, "R3", {tag, " page commands"}, cmd_count * 100 + page_bad, 800);
    check(wcount == BUFB && dup_wr == 0 && addr_bad == 0, "R4", {tag, " write count"},
          wcount + 10000 * (dup_wr + addr_bad), BUFB);
    for (int a = 0; a < BUFB; a++) if (mem[a] !== pat(a / MAINB, a % MAINB)) bad++;
    check(bad == 0, "R4", {tag, " buffer contents"}, bad, 0);
    check(spare_wr == 0, "R5", {tag, " spare bytes written"}, spare_wr, 0);
    check(rd_count == 7 * 528 + 512, "R5", {tag, " total reads"}, rd_count, 7 * 528 + 512);
    check(ready_cyc == last_we_cyc + 1, "R6", {tag, " ready timing"}, ready_cyc, last_we_cyc + 1);
    repeat (20) @(negedge clk);
    #2 check(post_act == 0 && boot_ready, "R10", {tag, " idle after ready"}, post_act, 0);
    core_addr = 32'h0001_2ABC;
    #1 check(fetch_en && buf_raddr == 12'hABC, "R8", {tag, " wrapped fetch"}, int'(buf_raddr), 'hABC);
    core_addr = 32'hFFFF_F007;
    #1 check(buf_raddr == 12'hFFF - 12'hFF8, "R8", {tag, " high fetch"}, int'(buf_raddr), 'h007);
    core_rd = 1'b0;
    #1 check(!fetch_en, "R8", {tag, " fetch follows core_rd"}, int'(fetch_en), 0);
  endtask

  task automatic t_no_flash();
    do_reset(1'b0, 8, 0, -1);
    @(negedge clk); #2;
    check(boot_ready, "R2", "ready one edge after release", int'(boot_ready), 1);
    repeat (10) @(negedge clk);
    #2 check(cmd_count == 0 && wcount == 0 && rd_count == 0, "R2", "no flash traffic",
             cmd_count + wcount + rd_count, 0);
  endtask

  task automatic t_timeout(int tmo, int stall_at, int exp_wr);
    do_reset(1'b1, tmo, 0, stall_at);
    core_rd = 1'b1;
    wait_end();
    check(load_err, "R7", "error raised", int'(load_err), 1);
    check(err_cyc == stall_start + tmo, "R7", "error cycle", err_cyc, stall_start + tmo);
    repeat (30) @(negedge clk);
    #2 check(!fl_rd_req && !boot_ready && wcount == exp_wr, "R7", "halted after error",
             wcount, exp_wr);
    check(!fetch_en, "R9", "no fetch after error", int'(fetch_en), 0);
  endtask

  initial begin
    rst_n = 1'b0; boot_flash = 1'b0; ack_timeout = 16'd4;
    core_rd = 1'b0; core_addr = '0; fl_rd_ack = 1'b0; fl_rd_data = '0;
    fork
      begin
        t_reset_state();
        t_full_load(4, 0, "fast");
        t_no_flash();
        t_full_load(3, 2, "slow_edge");
        t_timeout(6, 600, 584);
        t_timeout(1, 3, 3);
      end
      begin
        repeat (150000) @(negedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule